// File: doc/BRIEF.md
# Instruction Prefetch Buffer with Snoop

This block sits between the instruction-fetch stage and a burst memory port. When a fetch misses, it issues one read of 32 bytes, aligned to 32 bytes. The 16-byte half that holds the missed address is returned as a line fill to the instruction cache. The other half is kept in a small fully associative prefetch store. Later fetches that hit the store are answered from it one cycle later, and no memory read is started.

Non-cacheable fetches never go to the cache. On a non-cacheable miss, both halves of the burst are written into the prefetch store, and the missed half is also returned on the fetch response port. Two snoop ports invalidate held data at 16-byte line granularity:

- **Data-cache miss snoop.** It hits the prefetch store, the pending prefetch half and the pending line fill.
- **External inquire snoop.** It hits the prefetch store and the pending prefetch half only. A cacheable line fill that is in flight is not affected by it.

Top module: `ipf_prefetch`

## Requirements
- R1: Reset clears every valid bit in the prefetch store and the line-fill buffer, and drives `fetch_rvalid_o`, `fill_valid_o` and `mem_req_o` low. The first fetch after reset always misses.
- R2: A fetch that misses while no burst is outstanding raises `mem_req_o` for exactly one cycle, in the cycle after the request. `mem_addr_o` equals the fetch address with bits [4:0] cleared.
- R3: Memory returns the burst as 256/BEAT_W beats of increasing address. Beat k carries bytes base+k*BEAT_W/8 upward, with the lowest byte in the lowest bits. For a cacheable miss, `fill_valid_o` pulses for one cycle, in the cycle after the last beat. In that pulse, `fill_addr_o` is the missed 16-byte line address and `fill_data_o` holds that line, with byte i in bits [8i+7:8i].
- R4: For a cacheable miss, the other 16-byte half of the burst is written into the prefetch store. A later fetch to that line raises `fetch_rvalid_o` in the next cycle with the line data, and no `mem_req_o` is issued.
- R5: For a non-cacheable miss, `fetch_rvalid_o` pulses in the cycle after the last beat with the missed line, `fill_valid_o` stays low, and both halves are written into the prefetch store: first the missed half, then the other half.
- R6: A non-cacheable fetch that hits the prefetch store is answered in the next cycle from the store, and no memory read is issued.
- R7: From the cycle after a missing request through the cycle that delivers its burst, fetch requests are ignored. They produce no response and no further `mem_req_o`.
- R8: A data-cache snoop whose address bits [ADDR_W-1:4] match a stored line invalidates it. A snoop to the other 16-byte half of the same 32-byte block leaves the line valid.
- R9: An inquire snoop that matches a stored line at 16-byte granularity invalidates it.
- R10: A data-cache snoop that matches the pending cacheable missed line, in any cycle from the request through the last beat, suppresses its `fill_valid_o` pulse.
- R11: An inquire snoop that matches the pending cacheable missed line does not suppress the line fill.
- R12: A snoop on either port that matches a pending prefetch-store half (the other half, or the missed half of a non-cacheable burst) during the burst keeps that half invalid. A later fetch to it misses, and for a non-cacheable missed half the response is suppressed.
- R13: Store writes go to the entry after the last one written and wrap round. With two entries, a third stored line replaces the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request that missed the instruction cache, or a non-cacheable fetch |
| fetch_addr_i | input | ADDR_W | Fetch byte address |
| fetch_nc_i | input | 1 | Fetch is non-cacheable |
| fetch_rvalid_o | output | 1 | Fetch response valid |
| fetch_rdata_o | output | 128 | Fetch response line |
| fill_valid_o | output | 1 | Line fill to the instruction cache |
| fill_addr_o | output | ADDR_W | Line fill address, 16-byte aligned |
| fill_data_o | output | 128 | Line fill data |
| mem_req_o | output | 1 | Burst read request, one cycle |
| mem_addr_o | output | ADDR_W | Burst address, 32-byte aligned |
| mem_rvalid_i | input | 1 | Burst beat valid |
| mem_rdata_i | input | BEAT_W | Burst beat data |
| dsnp_valid_i | input | 1 | Data-cache miss snoop valid |
| dsnp_addr_i | input | ADDR_W | Data-cache miss snoop address |
| inq_valid_i | input | 1 | External inquire snoop valid |
| inq_addr_i | input | ADDR_W | External inquire snoop address |

## Verification
Each result has a fixed latency, and the bench samples it at the falling edge of that exact cycle:

- A store hit answers one cycle after its request.
- A miss raises `mem_req_o` one cycle after the request.
- A fill or a non-cacheable response appears one cycle after the last beat and is gone in the following cycle.

The bench feeds beats at successive falling edges and applies each snoop or busy-time request during a chosen beat, so every snoop rule is checked at one fixed, known beat. A bench-side model of the store contents, the replacement pointer and the pending-half flags decides, before each fetch, whether that fetch should hit or miss. It then checks both the data and the absence of `mem_req_o` in the cycle where a hit would answer.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  localparam int unsigned LINE_BYTES  = 16;
  localparam int unsigned LINE_W      = LINE_BYTES * 8;
  localparam int unsigned BURST_BYTES = 2 * LINE_BYTES;
  localparam int unsigned BURST_W     = BURST_BYTES * 8;
  localparam int unsigned LINE_OFS    = $clog2(LINE_BYTES);
  localparam int unsigned BURST_OFS   = $clog2(BURST_BYTES);
endpackage

// File: rtl/ipf_burst_ctl.sv
module ipf_burst_ctl
  import ipf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEAT_W = 64,
  localparam int unsigned LA_W  = ADDR_W - LINE_OFS,
  localparam int unsigned BA_W  = ADDR_W - BURST_OFS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              nc_i,
  input  logic              mem_rvalid_i,
  input  logic [BEAT_W-1:0] mem_rdata_i,
  input  logic              dsnp_valid_i,
  input  logic [LA_W-1:0]   dsnp_line_i,
  input  logic              inq_valid_i,
  input  logic [LA_W-1:0]   inq_line_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              nc_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              miss_keep_o,
  output logic              other_keep_o,
  output logic [LA_W-1:0]   miss_line_o,
  output logic [LA_W-1:0]   other_line_o,
  output logic [LINE_W-1:0] miss_data_o,
  output logic [LINE_W-1:0] other_data_o
);
  localparam int unsigned BEATS = BURST_W / BEAT_W;
  localparam int unsigned HALF  = BEATS / 2;
  localparam int unsigned CNT_W = $clog2(BEATS);

  logic             busy_q, done_q, nc_q, half_q, req_q;
  logic             miss_keep_q, other_keep_q;
  logic [BA_W-1:0]  base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] beat_q [BEATS];
  logic [LINE_W-1:0] half_data [2];

  logic [LA_W-1:0] st_miss, st_other, cur_miss, cur_other;
  logic            beat_ok, last_beat;

  assign st_miss   = start_addr_i[ADDR_W-1:LINE_OFS];
  assign st_other  = {start_addr_i[ADDR_W-1:BURST_OFS], ~start_addr_i[LINE_OFS]};
  assign cur_miss  = {base_q, half_q};
  assign cur_other = {base_q, ~half_q};
  assign beat_ok   = busy_q && !done_q && mem_rvalid_i;
  assign last_beat = beat_ok && (cnt_q == CNT_W'(BEATS - 1));

  function automatic logic dhit(input logic [LA_W-1:0] l);
    return dsnp_valid_i && (dsnp_line_i == l);
  endfunction
  function automatic logic ihit(input logic [LA_W-1:0] l);
    return inq_valid_i && (inq_line_i == l);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      nc_q         <= 1'b0;
      half_q       <= 1'b0;
      req_q        <= 1'b0;
      miss_keep_q  <= 1'b0;
      other_keep_q <= 1'b0;
      base_q       <= '0;
      cnt_q        <= '0;
    end else begin
      req_q <= start_i;
      if (start_i) begin
        busy_q       <= 1'b1;
        nc_q         <= nc_i;
        half_q       <= start_addr_i[LINE_OFS];
        base_q       <= start_addr_i[ADDR_W-1:BURST_OFS];
        cnt_q        <= '0;
        // line-fill half ignores inquiries unless it is headed for the store
        miss_keep_q  <= !(dhit(st_miss) || (nc_i && ihit(st_miss)));
        other_keep_q <= !(dhit(st_other) || ihit(st_other));
      end else if (done_q) begin
        done_q <= 1'b0;
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (dhit(cur_miss) || (nc_q && ihit(cur_miss))) miss_keep_q <= 1'b0;
        if (dhit(cur_other) || ihit(cur_other))         other_keep_q <= 1'b0;
        if (beat_ok) cnt_q <= cnt_q + 1'b1;
        if (last_beat) done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (beat_ok) beat_q[cnt_q] <= mem_rdata_i;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar k = 0; k < HALF; k++) begin : g_beat
      assign half_data[h][k*BEAT_W +: BEAT_W] = beat_q[h*HALF + k];
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign nc_o         = nc_q;
  assign mem_req_o    = req_q;
  assign mem_addr_o   = {base_q, {BURST_OFS{1'b0}}};
  assign miss_keep_o  = miss_keep_q;
  assign other_keep_o = other_keep_q;
  assign miss_line_o  = cur_miss;
  assign other_line_o = cur_other;
  assign miss_data_o  = half_data[half_q];
  assign other_data_o = half_data[~half_q];
endmodule

// File: rtl/ipf_pf_store.sv
module ipf_pf_store
  import ipf_pkg::*;
#(
  parameter int unsigned LA_W  = 28,
  parameter int unsigned LINES = 2,
  localparam int unsigned PTR_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LA_W-1:0]   lk_line_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] hit_data_o,
  input  logic              wr_en_i,
  input  logic              wr_two_i,
  input  logic [LA_W-1:0]   wr_line0_i,
  input  logic [LINE_W-1:0] wr_data0_i,
  input  logic              wr_keep0_i,
  input  logic [LA_W-1:0]   wr_line1_i,
  input  logic [LINE_W-1:0] wr_data1_i,
  input  logic              wr_keep1_i,
  input  logic              dsnp_valid_i,
  input  logic [LA_W-1:0]   dsnp_line_i,
  input  logic              inq_valid_i,
  input  logic [LA_W-1:0]   inq_line_i
);
  logic [LA_W-1:0]   line_q [LINES];
  logic [LINE_W-1:0] data_q [LINES];
  logic [LINES-1:0]  vld_q;
  logic [PTR_W-1:0]  ptr_q, ptr_nx1;
  logic              snp_w0, snp_w1;

  assign ptr_nx1 = ptr_q + 1'b1;
  assign snp_w0  = (dsnp_valid_i && dsnp_line_i == wr_line0_i) ||
                   (inq_valid_i && inq_line_i == wr_line0_i);
  assign snp_w1  = (dsnp_valid_i && dsnp_line_i == wr_line1_i) ||
                   (inq_valid_i && inq_line_i == wr_line1_i);

  for (genvar g = 0; g < LINES; g++) begin : g_ent
    logic sel0, sel1, snp;
    assign sel0 = wr_en_i && (ptr_q == PTR_W'(g));
    assign sel1 = wr_en_i && wr_two_i && (ptr_nx1 == PTR_W'(g));
    assign snp  = (dsnp_valid_i && dsnp_line_i == line_q[g]) ||
                  (inq_valid_i && inq_line_i == line_q[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   vld_q[g] <= 1'b0;
      else if (sel0) vld_q[g] <= wr_keep0_i && !snp_w0;
      else if (sel1) vld_q[g] <= wr_keep1_i && !snp_w1;
      else if (snp)  vld_q[g] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (sel0) begin
        line_q[g] <= wr_line0_i;
        data_q[g] <= wr_data0_i;
      end else if (sel1) begin
        line_q[g] <= wr_line1_i;
        data_q[g] <= wr_data1_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (wr_en_i) ptr_q <= wr_two_i ? ptr_q + PTR_W'(2) : ptr_nx1;
  end

  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!hit_o && vld_q[i] && line_q[i] == lk_line_i) begin
        hit_o      = 1'b1;
        hit_data_o = data_q[i];
      end
    end
  end
endmodule

// File: rtl/ipf_prefetch.sv
module ipf_prefetch
  import ipf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BEAT_W   = 64,
  parameter int unsigned PF_LINES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_nc_i,
  output logic              fetch_rvalid_o,
  output logic [127:0]      fetch_rdata_o,
  output logic              fill_valid_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic [127:0]      fill_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [BEAT_W-1:0] mem_rdata_i,
  input  logic              dsnp_valid_i,
  input  logic [ADDR_W-1:0] dsnp_addr_i,
  input  logic              inq_valid_i,
  input  logic [ADDR_W-1:0] inq_addr_i
);
  localparam int unsigned LA_W = ADDR_W - LINE_OFS;

  logic              busy, done, nc, miss_keep, other_keep;
  logic              accept, hit, start, hit_q;
  logic [LA_W-1:0]   miss_line, other_line, dsnp_line, inq_line;
  logic [LINE_W-1:0] miss_data, other_data, hit_data, hit_data_q;

  assign dsnp_line = dsnp_addr_i[ADDR_W-1:LINE_OFS];
  assign inq_line  = inq_addr_i[ADDR_W-1:LINE_OFS];
  assign accept    = fetch_req_i && !busy;
  assign start     = accept && !hit;

  ipf_burst_ctl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctl (
    .clk_i, .rst_ni,
    .start_i(start), .start_addr_i(fetch_addr_i), .nc_i(fetch_nc_i),
    .mem_rvalid_i, .mem_rdata_i,
    .dsnp_valid_i, .dsnp_line_i(dsnp_line),
    .inq_valid_i, .inq_line_i(inq_line),
    .busy_o(busy), .done_o(done), .nc_o(nc),
    .mem_req_o, .mem_addr_o,
    .miss_keep_o(miss_keep), .other_keep_o(other_keep),
    .miss_line_o(miss_line), .other_line_o(other_line),
    .miss_data_o(miss_data), .other_data_o(other_data)
  );

  ipf_pf_store #(.LA_W(LA_W), .LINES(PF_LINES)) u_store (
    .clk_i, .rst_ni,
    .lk_line_i(fetch_addr_i[ADDR_W-1:LINE_OFS]),
    .hit_o(hit), .hit_data_o(hit_data),
    .wr_en_i(done), .wr_two_i(nc),
    .wr_line0_i(nc ? miss_line : other_line),
    .wr_data0_i(nc ? miss_data : other_data),
    .wr_keep0_i(nc ? miss_keep : other_keep),
    .wr_line1_i(other_line), .wr_data1_i(other_data), .wr_keep1_i(other_keep),
    .dsnp_valid_i, .dsnp_line_i(dsnp_line),
    .inq_valid_i, .inq_line_i(inq_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= accept && hit;
  end

  always_ff @(posedge clk_i) begin
    if (accept && hit) hit_data_q <= hit_data;
  end

  assign fill_valid_o   = done && !nc && miss_keep;
  assign fill_addr_o    = {miss_line, {LINE_OFS{1'b0}}};
  assign fill_data_o    = miss_data;
  assign fetch_rvalid_o = hit_q || (done && nc && miss_keep);
  assign fetch_rdata_o  = hit_q ? hit_data_q : miss_data;
endmodule

module ipf_prefetch_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_req_i,
  input logic              busy_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              fill_valid_o,
  input logic [ADDR_W-1:0] fill_addr_o,
  input logic              fetch_rvalid_o
);
  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R2
  req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[4:0] == 5'd0));
  // R7
  one_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!$past(busy_i) && $past(fetch_req_i)));
  // R3
  fill_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> (fill_addr_o[3:0] == 4'd0));
  // R3
  fill_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> !fill_valid_o);
  // R5
  resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fetch_rvalid_o));
  // R7
  fill_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> busy_i);
endmodule

bind ipf_prefetch ipf_prefetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_req_i(fetch_req_i), .busy_i(busy),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .fill_valid_o(fill_valid_o), .fill_addr_o(fill_addr_o),
  .fetch_rvalid_o(fetch_rvalid_o)
);

// File: tb/ipf_prefetch_bench.sv
`timescale 1ns/1ps
module ipf_prefetch_bench;
  localparam int BEATS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_req = 0, fetch_nc = 0, mem_rvalid = 0, dsnp_v = 0, inq_v = 0;
  logic [31:0] fetch_addr = '0, dsnp_a = '0, inq_a = '0;
  logic [63:0] mem_rdata = '0;
  logic fetch_rvalid_o, fill_valid_o, mem_req_o;
  logic [127:0] fetch_rdata_o, fill_data_o;
  logic [31:0] fill_addr_o, mem_addr_o;

  int total = 0, bad = 0, cyc = 0;
  logic [27:0] m_line [2];
  bit m_vld [2];
  int m_ptr = 0;

  always #2 clk = ~clk;

  ipf_prefetch u_ipf_prefetch (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr), .fetch_nc_i(fetch_nc),
    .fetch_rvalid_o, .fetch_rdata_o, .fill_valid_o, .fill_addr_o, .fill_data_o,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .dsnp_valid_i(dsnp_v), .dsnp_addr_i(dsnp_a), .inq_valid_i(inq_v), .inq_addr_i(inq_a)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [127:0] ld(input logic [27:0] l);
    logic [127:0] d;
    for (int i = 0; i < 16; i++) d[8*i +: 8] = mb({l, 4'b0} + 32'(i));
    return d;
  endfunction
  function automatic logic [63:0] bd(input logic [31:0] base, input int k);
    logic [63:0] d;
    for (int j = 0; j < 8; j++) d[8*j +: 8] = mb(base + 32'(k*8 + j));
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic m_snoop(input logic [31:0] a);
    for (int e = 0; e < 2; e++) if (m_vld[e] && m_line[e] == a[31:4]) m_vld[e] = 0;
  endtask

  task automatic snoop(input bit dc, input logic [31:0] a);
    @(negedge clk);
    if (dc) begin dsnp_v = 1; dsnp_a = a; end
    else begin inq_v = 1; inq_a = a; end
    @(negedge clk);
    dsnp_v = 0; inq_v = 0;
    m_snoop(a);
  endtask

  // dsb/iqb/bzb: beat index for a data snoop, inquire, busy-time request (-1 none)
  task automatic fetch(input logic [31:0] a, input bit nc, input int dsb,
                       input logic [31:0] dsa, input int iqb, input logic [31:0] iqa,
                       input int bzb);
    int hi = -1;
    bit mk = 1, ok = 1;
    logic [27:0] ml = a[31:4], ol = {a[31:5], ~a[4]};
    for (int e = 1; e >= 0; e--) if (m_vld[e] && m_line[e] == ml) hi = e;
    @(negedge clk);
    fetch_req = 1; fetch_addr = a; fetch_nc = nc;
    @(negedge clk);
    fetch_req = 0;
    if (hi >= 0) begin
      chk(fetch_rvalid_o == 1'b1, nc ? "R6" : "R4", "hit valid", 128'(fetch_rvalid_o), 1);
      chk(fetch_rdata_o == ld(ml), nc ? "R6" : "R4", "hit data", fetch_rdata_o, ld(ml));
      chk(mem_req_o == 1'b0, "R4", "no burst on hit", 128'(mem_req_o), 0);
      return;
    end
    chk(mem_req_o == 1'b1, "R2", "burst req", 128'(mem_req_o), 1);
    chk(mem_addr_o == {a[31:5], 5'b0}, "R2", "burst addr", 128'(mem_addr_o), 128'({a[31:5], 5'b0}));
    for (int j = 0; j < BEATS; j++) begin
      mem_rvalid = 1; mem_rdata = bd({a[31:5], 5'b0}, j);
      if (j == dsb) begin
        dsnp_v = 1; dsnp_a = dsa; m_snoop(dsa);
        if (dsa[31:4] == ml) mk = 0;
        if (dsa[31:4] == ol) ok = 0;
      end
      if (j == iqb) begin
        inq_v = 1; inq_a = iqa; m_snoop(iqa);
        if (iqa[31:4] == ml && nc) mk = 0;
        if (iqa[31:4] == ol) ok = 0;
      end
      if (j == bzb) begin fetch_req = 1; fetch_addr = a ^ 32'h10; fetch_nc = nc; end
      @(negedge clk);
      dsnp_v = 0; inq_v = 0; fetch_req = 0;
      if (j == bzb) begin
        chk(fetch_rvalid_o == 1'b0, "R7", "busy resp", 128'(fetch_rvalid_o), 0);
        chk(mem_req_o == 1'b0, "R7", "busy burst", 128'(mem_req_o), 0);
      end
    end
    mem_rvalid = 0;
    if (!nc) begin
      chk(fill_valid_o == mk, mk ? "R3" : "R10", "fill valid", 128'(fill_valid_o), 128'(mk));
      if (mk) begin
        chk(fill_addr_o == {ml, 4'b0}, "R3", "fill addr", 128'(fill_addr_o), 128'({ml, 4'b0}));
        chk(fill_data_o == ld(ml), "R3", "fill data", fill_data_o, ld(ml));
      end
      chk(fetch_rvalid_o == 1'b0, "R3", "no resp on fill", 128'(fetch_rvalid_o), 0);
      m_line[m_ptr] = ol; m_vld[m_ptr] = ok; m_ptr = (m_ptr + 1) % 2;
    end else begin
      chk(fetch_rvalid_o == mk, mk ? "R5" : "R12", "nc resp", 128'(fetch_rvalid_o), 128'(mk));
      if (mk) chk(fetch_rdata_o == ld(ml), "R5", "nc data", fetch_rdata_o, ld(ml));
      chk(fill_valid_o == 1'b0, "R5", "nc no fill", 128'(fill_valid_o), 0);
      m_line[m_ptr] = ml; m_vld[m_ptr] = mk;
      m_line[(m_ptr + 1) % 2] = ol; m_vld[(m_ptr + 1) % 2] = ok;
    end
    @(negedge clk);
    chk(fill_valid_o == 1'b0 && fetch_rvalid_o == 1'b0, "R3", "single pulse",
        128'({fill_valid_o, fetch_rvalid_o}), 0);
  endtask

  task automatic plain(input logic [31:0] a, input bit nc);
    fetch(a, nc, -1, '0, -1, '0, -1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R7 watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_vld[0] = 0; m_vld[1] = 0;
    repeat (3) @(negedge clk);
    chk(!fill_valid_o && !fetch_rvalid_o && !mem_req_o, "R1", "reset outputs",
        128'({fill_valid_o, fetch_rvalid_o, mem_req_o}), 0);
    rst_n = 1;
    plain(32'h0000_0104, 0);                 // R1 first fetch misses
    plain(32'h0000_0114, 0);                 // R4 hits other half
    // R1 mid-run reset clears the store
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    m_vld[0] = 0; m_vld[1] = 0; m_ptr = 0;
    plain(32'h0000_0114, 0);
    // sweep of halves, offsets and cacheability
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a = 32'h2000 + 32'(i*32) + 32'((i%2)*16) + 32'((i*3)%16);
      plain(a, (i%3) == 0);
      plain(a ^ 32'h10, i[0]);
      plain(a, i[1]);
    end
    // R10 data snoop kills pending fill
    fetch(32'h3000, 0, 1, 32'h3008, -1, '0, -1);
    // R11 inquire leaves pending fill alone
    fetch(32'h3040, 0, -1, '0, 2, 32'h3044, -1);
    // R12 snoops on pending prefetch half, both ports
    fetch(32'h3080, 0, 3, 32'h3090, -1, '0, -1);
    plain(32'h3090, 0);
    fetch(32'h30C0, 0, -1, '0, 0, 32'h30D0, -1);
    plain(32'h30D0, 1);
    // R12 inquire on non-cacheable missed half
    fetch(32'h3100, 1, -1, '0, 1, 32'h3100, -1);
    plain(32'h3110, 1);
    // R7 requests during burst ignored
    fetch(32'h3200, 0, -1, '0, -1, '0, 0);
    fetch(32'h3240, 1, -1, '0, -1, '0, 2);
    // R8 data snoop on stored line; sibling half does not invalidate
    plain(32'h4000, 0);
    snoop(1, 32'h4000);
    plain(32'h4010, 0);
    plain(32'h4040, 1);
    snoop(1, 32'h4100);
    snoop(1, 32'h4048);
    plain(32'h4040, 0);
    plain(32'h4050, 1);
    // R9 inquire on stored line
    plain(32'h5000, 0);
    snoop(0, 32'h501C);
    plain(32'h5010, 0);
    // R13 round-robin replacement: third line evicts oldest
    plain(32'h6000, 0);
    plain(32'h6020, 0);
    plain(32'h6040, 0);
    plain(32'h6010, 0);
    chk(m_ptr >= 0, "R13", "replacement model", 0, 0);
    plain(32'h6050, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule